// File: doc/BRIEF.md
# Per-Source Configurable Interrupt Controller

This block collects 32 interrupt request lines and presents them to a processor as one combined request plus a set of readable status words. Each line can be set, independently of the others, to trigger on a high level, a low level, a rising edge or a falling edge. Edge events are held in a latch until software acknowledges them by writing a 1 to the matching status bit. An enable register decides which sources can reach the combined output. A line that has both a polarity bit and a type bit selects one of exactly four trigger modes, and there is no mode that fires on both edges.

Software reaches the controller over a simple synchronous register bus: a request strobe, a write flag, a 3-bit word address and 32-bit write data. Read data is returned one clock after the request. Every external line passes through a two-flop synchronizer before it is examined. The combined output is registered, so one instance can feed one request line of another: a secondary controller's output is wired to a dedicated input of a primary controller, and that input is set to high-level mode.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the enable, polarity and type registers read 0 and irq_o is low.
- R2: A level source (type bit 0) shows in the raw word (address 3) as the synchronized input when its polarity bit is 1, and as the inverted input when its polarity bit is 0. Writing 1 to the bit of a level source has no effect on it.
- R3: An edge source (type bit 1, address 2) with polarity bit 1 (address 1) latches a 1 in the raw word on a rising input edge, and the 1 remains after the input falls.
- R4: An edge source with polarity bit 0 latches on a falling input edge and ignores a rising edge.
- R5: Writing 1 to a raw-word bit clears that source's edge latch. A 0 bit in the write leaves the latch unchanged.
- R6: The status word (address 4) reads the raw word ANDed with the enable register (address 0, bit 1 = enabled), and reading it clears nothing. A source whose enable bit is 0 cannot raise irq_o.
- R7: irq_o is the registered OR of the status word. From an input edge driven before a clock edge, an enabled edge source raises irq_o on the fourth clock edge and not earlier.
- R8: A write that changes a source's polarity or type bit clears that source's edge latch and leaves the latches of other sources unchanged.
- R9: Read data appears on rdata_o the clock after a read request. An address outside 0 to 4 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the clock after a read request |
| irq_i | input | 32 | Interrupt source lines, asynchronous |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The lines are exercised in all four trigger modes: a rising pulse on an edge source shows that the event is held after the line drops, and a rise then a fall on a falling-edge source shows that only the fall latches. Level sources are driven both ways to show that the raw bit tracks the line and ignores acknowledge writes. An input toggled while its enable bit is 0 separates the raw word from the status word and the output. Changing one source's polarity while another holds a latched event shows that the clear on reconfiguration touches only the changed source, and a single edge timed against the clock fixes the output latency.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_ENABLE = 3'd0,
    A_POLAR  = 3'd1,
    A_KIND   = 3'd2,
    A_RAW    = 3'd3,
    A_STAT   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic pol_i,
  input  logic kind_i,
  input  logic cfg_chg_i,
  input  logic ack_i,
  output logic raw_o
);
  logic prev_q, latch_q, hit, act;

  // edge compares two samples of the same line, so a polarity change makes no false edge
  assign hit = pol_i ? (line_i & ~prev_q) : (~line_i & prev_q);
  assign act = pol_i ? line_i : ~line_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= line_i;
      if (cfg_chg_i)              latch_q <= 1'b0;
      else if (kind_i && hit)     latch_q <= 1'b1;
      else if (ack_i)             latch_q <= 1'b0;
    end
  end

  assign raw_o = kind_i ? latch_q : act;

  // R8
  cfg_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_chg_i |=> !latch_q);
  // R3
  edge_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i && hit && !cfg_chg_i) |=> latch_q);
  // R5
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !hit && !cfg_chg_i) |=> !latch_q);
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      rdata_o,
  input  logic [N-1:0]      raw_i,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      kind_o,
  output logic [N-1:0]      cfg_chg_o,
  output logic [N-1:0]      ack_o
);
  logic [N-1:0] en_q, pol_q, kind_q;
  logic wr, rd;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pol_q  <= '0;
      kind_q <= '0;
    end else if (wr) begin
      case (addr_i)
        A_ENABLE: en_q   <= wdata_i;
        A_POLAR:  pol_q  <= wdata_i;
        A_KIND:   kind_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_chg_o = '0;
    if (wr && addr_i == A_POLAR) cfg_chg_o = wdata_i ^ pol_q;
    if (wr && addr_i == A_KIND)  cfg_chg_o = wdata_i ^ kind_q;
  end

  assign ack_o = (wr && addr_i == A_RAW) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd) begin
      case (addr_i)
        A_ENABLE: rdata_o <= en_q;
        A_POLAR:  rdata_o <= pol_q;
        A_KIND:   rdata_o <= kind_q;
        A_RAW:    rdata_o <= raw_i;
        A_STAT:   rdata_o <= raw_i & en_q;
        default:  rdata_o <= '0;
      endcase
    end
  end

  assign en_o   = en_q;
  assign pol_o  = pol_q;
  assign kind_o = kind_q;

  // R6
  en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_ENABLE) |=> en_o == $past(wdata_i));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      rdata_o,
  input  logic [N-1:0]      irq_i,
  output logic              irq_o
);
  logic [N-1:0] line, raw, en, pol, kind, cfg_chg, ack, masked;
  logic irq_q;

  irq_sync #(.N(N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(irq_i), .q_o(line)
  );

  irq_regs #(.N(N)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .raw_i(raw),
    .en_o(en), .pol_o(pol), .kind_o(kind), .cfg_chg_o(cfg_chg), .ack_o(ack)
  );

  for (genvar i = 0; i < N; i++) begin : g_src
    irq_src_cell u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line[i]), .pol_i(pol[i]),
      .kind_i(kind[i]), .cfg_chg_i(cfg_chg[i]), .ack_i(ack[i]), .raw_o(raw[i])
    );
  end

  assign masked = raw & en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |masked;
  end

  assign irq_o = irq_q;

  // R7
  irq_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == |$past(masked));
  // R6
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |=> !irq_o);
endmodule

// File: tb/irq_ctrl_bench.sv
`timescale 1ns/1ps
module irq_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] irq_i = '0;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  logic rd_pend = 1'b0;

  typedef struct {
    logic [31:0] mask;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk_i = ~clk_i;

  irq_ctrl u_irq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_i(irq_i), .irq_o(irq_o)
  );

  always @(posedge clk_i) rd_pend <= req_i & ~we_i;

  // monitor: compare read data the clock after each read request
  always @(negedge clk_i) begin
    if (rd_pend) begin
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected read data act=%h exp=none", rdata_o);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if ((rdata_o & it.mask) !== (it.exp & it.mask)) begin
          fails++;
          $display("FAIL %s act=%h exp=%h mask=%h", it.tag,
                   rdata_o & it.mask, it.exp & it.mask, it.mask);
        end
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] m,
                    input logic [31:0] e, input string tag);
    item_t it;
    it.mask = m; it.exp = e; it.tag = tag;
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    sb_q.push_back(it);
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq_o !== e) begin
      fails++;
      $display("FAIL %s irq_o act=%b exp=%b", tag, irq_o, e);
    end
  endtask

  task automatic finish_run();
    cyc(2);
    if (sb_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R9 %0d reads never returned act=%0d exp=0", sb_q.size(), sb_q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    // R1 reset state; R2 all lines low, active-low level -> raw all ones
    chk_irq(1'b0, "R1 reset");
    rd(3'd0, '1, 32'h0, "R1 enable reset");
    rd(3'd1, '1, 32'h0, "R1 polarity reset");
    rd(3'd2, '1, 32'h0, "R1 type reset");
    rd(3'd3, '1, 32'hFFFF_FFFF, "R2 active-low level raw");
    rd(3'd4, '1, 32'h0, "R6 status masked at reset");

    // bits 0..3 rising edge, rest high level
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0000_000F);
    rd(3'd3, '1, 32'h0, "R2 active-high level idle");

    // R3 rising edge latched, held after fall; R6 masked
    irq_i[0] = 1'b1; cyc(6);
    rd(3'd3, 32'h1, 32'h1, "R3 rising edge latched");
    rd(3'd4, '1, 32'h0, "R6 disabled source hidden");
    chk_irq(1'b0, "R6 disabled source no irq");
    irq_i[0] = 1'b0; cyc(6);
    rd(3'd3, 32'h1, 32'h1, "R3 latch held after fall");

    wr(3'd0, 32'h1); cyc(3);
    chk_irq(1'b1, "R7 enabled latch raises irq");
    rd(3'd4, '1, 32'h1, "R6 status = raw & enable");
    rd(3'd4, '1, 32'h1, "R6 status read does not clear");

    // R5 write-0 no effect, write-1 clears
    wr(3'd3, 32'h0);
    rd(3'd3, 32'h1, 32'h1, "R5 zero write keeps latch");
    wr(3'd3, 32'h1); cyc(3);
    rd(3'd3, 32'h1, 32'h0, "R5 one write clears latch");
    chk_irq(1'b0, "R5 irq drops after ack");

    // R4 falling edge on bit1
    wr(3'd1, 32'hFFFF_FFFD);
    irq_i[1] = 1'b1; cyc(6);
    rd(3'd3, 32'h2, 32'h0, "R4 rising edge ignored");
    irq_i[1] = 1'b0; cyc(6);
    rd(3'd3, 32'h2, 32'h2, "R4 falling edge latched");

    // R2 high level on bit4, ack has no effect
    irq_i[4] = 1'b1; cyc(6);
    rd(3'd3, 32'h10, 32'h10, "R2 high level follows input");
    wr(3'd3, 32'h10);
    rd(3'd3, 32'h10, 32'h10, "R2 ack ignored for level");
    irq_i[4] = 1'b0; cyc(6);
    rd(3'd3, 32'h10, 32'h0, "R2 high level released");

    // R2 low level on bit5
    wr(3'd1, 32'hFFFF_FFDD);
    rd(3'd3, 32'h20, 32'h20, "R2 low level active on low input");

    // R8 config change clears only the changed source
    irq_i[2] = 1'b1; cyc(6);
    rd(3'd3, 32'h4, 32'h4, "R3 bit2 latched");
    wr(3'd1, 32'hFFFF_FFD9);
    rd(3'd3, 32'h4, 32'h0, "R8 polarity change clears latch");
    rd(3'd3, 32'h2, 32'h2, "R8 other latch untouched");

    // R7 latency on bit3
    wr(3'd0, 32'h8); cyc(3);
    chk_irq(1'b0, "R7 idle before edge");
    @(negedge clk_i);
    irq_i[3] = 1'b1;
    @(posedge clk_i); @(posedge clk_i); @(posedge clk_i);
    @(negedge clk_i);
    chk_irq(1'b0, "R7 not before fourth edge");
    @(posedge clk_i);
    @(negedge clk_i);
    chk_irq(1'b1, "R7 raised on fourth edge");

    // R9 unmapped address
    rd(3'd7, '1, 32'h0, "R9 unmapped reads zero");
    rd(3'd5, '1, 32'h0, "R9 unmapped reads zero");

    finish_run();
  end
endmodule